// File: doc/BRIEF.md
# USB Endpoint Event Interrupt Bank

This block gathers the event pulses of a USB device controller into two status words and two enable words, and drives one interrupt line. Every endpoint reports two events, a FIFO error and a packet completion. The packet-complete and FIFO-error bits of endpoints 0 to 15 fill the first pair of words. Endpoints 16 and above go into the low half of the second pair. The top of the second pair holds the device-wide events: suspend, resume, configuration change and bus reset.

Firmware reads and writes the four words through a plain register port with one-cycle read latency. It sets enables to choose which events raise the interrupt. It acknowledges events by writing ones to the status words. A status bit records its event whether or not that event is enabled, so software can also poll with every enable at zero.

Register addresses on `regAddr`: 0 = endpoint/low enable word, 1 = high enable word, 2 = low status word, 3 = high status word.

Top module: `usb_evt_irq`

## Requirements
- R1: For endpoint n below 16, the low words use bit 2n for its FIFO error and bit 2n+1 for its packet completion.
- R2: For endpoint n from 16 up, the high words use bit 2(n-16) for its FIFO error and bit 2(n-16)+1 for its packet completion.
- R3: The device events `devEvent[3:0]` (suspend, resume, configuration change, bus reset) set high-word bits 28, 29, 30 and 31 respectively. High-word bit 27 is part of the device field but has no source and reads zero.
- R4: A status bit sets in the cycle after its event pulse, whatever its enable holds, and keeps its value until it is cleared.
- R5: Writing a status word clears each bit written with 1 and leaves each bit written with 0 unchanged.
- R6: When an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: `irq` is a register holding the OR, over every bit, of status AND enable. It rises one clock after the cycle in which a matching status/enable pair first exists.
- R8: With both enable words at zero, `irq` is low from the second cycle on, whatever the status holds.
- R9: High-word bits 16 to 27 are not implemented. In both the enable and the status word they read zero and ignore writes. All 32 bits of the low words are implemented.
- R10: A read request returns its data on `regRdData` one cycle later. The data is the register contents before any update made in the request cycle.
- R11: After reset, all four words and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write request |
| regRdEn | input | 1 | Register read request |
| regAddr | input | 2 | Register select (0 enable low, 1 enable high, 2 status low, 3 status high) |
| regWrData | input | 32 | Write data (enable value or clear mask) |
| regRdData | output | 32 | Read data, valid the cycle after a read request |
| epFifoErr | input | NUM_EP | Per-endpoint FIFO error pulses |
| epPktDone | input | NUM_EP | Per-endpoint packet-complete pulses |
| devEvent | input | 4 | Device event pulses: suspend, resume, configuration change, bus reset |
| irq | output | 1 | Registered interrupt request |

## Verification
An event pulse that lands in the same cycle as a write-one-to-clear of the same status word makes the set path and the clear path compete for one flop. The bench provokes this on purpose. It clears the whole high status word while endpoint 20 reports a FIFO error, and it also mixes random pulses with random clearing writes. The behavioural model lets the pulse win, and the design is compared with that model on the read data and on `irq` at every clock. A read issued in the same cycle as a pulse is also checked, to confirm that it returns the value from before the update.

// File: rtl/usb_evt_irq_pkg.sv
`timescale 1ns/1ps
package usb_evt_irq_pkg;

  localparam int REG_W = 32;

  localparam logic [1:0] ADDR_EN_LO = 2'd0;
  localparam logic [1:0] ADDR_EN_HI = 2'd1;
  localparam logic [1:0] ADDR_ST_LO = 2'd2;
  localparam logic [1:0] ADDR_ST_HI = 2'd3;

  typedef struct packed {
    logic       enLoWr;
    logic       enHiWr;
    logic       stLoClr;
    logic       stHiClr;
    logic       rdReq;
    logic [1:0] rdSel;
  } bank_strobe_t;

  // Implemented-bit mask of the high word: endpoint bits at the bottom,
  // device bits at the top.
  function automatic logic [REG_W-1:0] hi_impl_mask(input int hiEpBits, input int numDev);
    logic [REG_W-1:0] m;
    for (int b = 0; b < REG_W; b++) begin
      m[b] = (b < hiEpBits) || (b >= REG_W - numDev);
    end
    return m;
  endfunction

endpackage

// File: rtl/usb_evt_irq_ctrl.sv
`timescale 1ns/1ps
module usb_evt_irq_ctrl
  import usb_evt_irq_pkg::*;
(
  input  logic         regWrEn,
  input  logic         regRdEn,
  input  logic [1:0]   regAddr,
  output bank_strobe_t strb
);

  always_comb begin
    strb         = '0;
    strb.enLoWr  = regWrEn && (regAddr == ADDR_EN_LO);
    strb.enHiWr  = regWrEn && (regAddr == ADDR_EN_HI);
    strb.stLoClr = regWrEn && (regAddr == ADDR_ST_LO);
    strb.stHiClr = regWrEn && (regAddr == ADDR_ST_HI);
    strb.rdReq   = regRdEn;
    strb.rdSel   = regAddr;
  end

endmodule

// File: rtl/usb_evt_irq_evmap.sv
`timescale 1ns/1ps
module usb_evt_irq_evmap
  import usb_evt_irq_pkg::*;
#(
  parameter int NUM_EP  = 24,
  parameter int NUM_DEV = 4
) (
  input  logic [NUM_EP-1:0]  epFifoErr,
  input  logic [NUM_EP-1:0]  epPktDone,
  input  logic [NUM_DEV-1:0] devEvent,
  output logic [REG_W-1:0]   evLo,
  output logic [REG_W-1:0]   evHi
);

  localparam int LO_EPS     = REG_W / 2;
  localparam int HI_EP_BITS = (NUM_EP > LO_EPS) ? 2 * (NUM_EP - LO_EPS) : 0;
  localparam int DEV_BASE   = REG_W - NUM_DEV;

  for (genvar b = 0; b < REG_W; b++) begin : g_lo
    if (b / 2 >= NUM_EP) begin : g_none
      assign evLo[b] = 1'b0;
    end else if (b % 2 == 1) begin : g_pkt
      assign evLo[b] = epPktDone[b / 2];
    end else begin : g_err
      assign evLo[b] = epFifoErr[b / 2];
    end
  end

  for (genvar b = 0; b < REG_W; b++) begin : g_hi
    if (b < HI_EP_BITS) begin : g_ep
      if (b % 2 == 1) begin : g_pkt
        assign evHi[b] = epPktDone[LO_EPS + b / 2];
      end else begin : g_err
        assign evHi[b] = epFifoErr[LO_EPS + b / 2];
      end
    end else if (b >= DEV_BASE) begin : g_dev
      assign evHi[b] = devEvent[b - DEV_BASE];
    end else begin : g_none
      assign evHi[b] = 1'b0;
    end
  end

endmodule

// File: rtl/usb_evt_irq_word.sv
`timescale 1ns/1ps
module usb_evt_irq_word
  import usb_evt_irq_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enWr,
  input  logic             stClr,
  input  logic [REG_W-1:0] wrData,
  input  logic [REG_W-1:0] ev,
  output logic [REG_W-1:0] en,
  output logic [REG_W-1:0] st,
  output logic             pend
);

  logic [REG_W-1:0] clrMask;

  assign clrMask = stClr ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      en <= '0;
      st <= '0;
    end else begin
      if (enWr) en <= wrData & IMPL;
      // set path ORed after the clear so a same-cycle pulse survives
      st <= ((st & ~clrMask) | ev) & IMPL;
    end
  end

  assign pend = |(st & en);

endmodule

// File: rtl/usb_evt_irq_bank.sv
`timescale 1ns/1ps
module usb_evt_irq_bank
  import usb_evt_irq_pkg::*;
#(
  parameter int NUM_EP  = 24,
  parameter int NUM_DEV = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  bank_strobe_t     strb,
  input  logic [REG_W-1:0] wrData,
  input  logic [REG_W-1:0] evLo,
  input  logic [REG_W-1:0] evHi,
  output logic [REG_W-1:0] enLo,
  output logic [REG_W-1:0] enHi,
  output logic [REG_W-1:0] stLo,
  output logic [REG_W-1:0] stHi,
  output logic [REG_W-1:0] rdData,
  output logic             irq
);

  localparam int LO_EPS     = REG_W / 2;
  localparam int HI_EP_BITS = (NUM_EP > LO_EPS) ? 2 * (NUM_EP - LO_EPS) : 0;
  localparam logic [REG_W-1:0] HI_IMPL = hi_impl_mask(HI_EP_BITS, NUM_DEV);

  localparam int NUM_WORDS = 2;

  logic [REG_W-1:0] enW   [NUM_WORDS];
  logic [REG_W-1:0] stW   [NUM_WORDS];
  logic [NUM_WORDS-1:0] pendW;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam logic [REG_W-1:0] IMPL_W = (w == 0) ? '1 : HI_IMPL;
    logic             enWrSel;
    logic             stClrSel;
    logic [REG_W-1:0] evSel;

    assign enWrSel  = (w == 0) ? strb.enLoWr  : strb.enHiWr;
    assign stClrSel = (w == 0) ? strb.stLoClr : strb.stHiClr;
    assign evSel    = (w == 0) ? evLo : evHi;

    usb_evt_irq_word #(.IMPL(IMPL_W)) i_word (
      .clk    (clk),
      .rstN   (rstN),
      .enWr   (enWrSel),
      .stClr  (stClrSel),
      .wrData (wrData),
      .ev     (evSel),
      .en     (enW[w]),
      .st     (stW[w]),
      .pend   (pendW[w])
    );
  end

  assign enLo = enW[0];
  assign enHi = enW[1];
  assign stLo = stW[0];
  assign stHi = stW[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= |pendW;
      if (strb.rdReq) begin
        unique case (strb.rdSel)
          ADDR_EN_LO: rdData <= enW[0];
          ADDR_EN_HI: rdData <= enW[1];
          ADDR_ST_LO: rdData <= stW[0];
          default:    rdData <= stW[1];
        endcase
      end
    end
  end

endmodule

// File: rtl/usb_evt_irq.sv
`timescale 1ns/1ps
module usb_evt_irq
  import usb_evt_irq_pkg::*;
#(
  parameter int NUM_EP  = 24,
  parameter int NUM_DEV = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [1:0]         regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  logic [NUM_EP-1:0]  epFifoErr,
  input  logic [NUM_EP-1:0]  epPktDone,
  input  logic [NUM_DEV-1:0] devEvent,
  output logic               irq
);

  bank_strobe_t     strb;
  logic [REG_W-1:0] evLo, evHi;
  logic [REG_W-1:0] enLo, enHi, stLo, stHi;

  usb_evt_irq_ctrl i_ctrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  usb_evt_irq_evmap #(.NUM_EP(NUM_EP), .NUM_DEV(NUM_DEV)) i_evmap (
    .epFifoErr (epFifoErr),
    .epPktDone (epPktDone),
    .devEvent  (devEvent),
    .evLo      (evLo),
    .evHi      (evHi)
  );

  usb_evt_irq_bank #(.NUM_EP(NUM_EP), .NUM_DEV(NUM_DEV)) i_bank (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (regWrData),
    .evLo   (evLo),
    .evHi   (evHi),
    .enLo   (enLo),
    .enHi   (enHi),
    .stLo   (stLo),
    .stHi   (stHi),
    .rdData (regRdData),
    .irq    (irq)
  );

endmodule

// File: rtl/usb_evt_irq_chk.sv
`timescale 1ns/1ps
module usb_evt_irq_chk
  import usb_evt_irq_pkg::*;
#(
  parameter int NUM_EP  = 24,
  parameter int NUM_DEV = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             regRdEn,
  input logic [1:0]       regAddr,
  input logic [REG_W-1:0] regWrData,
  input logic [REG_W-1:0] regRdData,
  input logic             irq,
  input logic [REG_W-1:0] evLo,
  input logic [REG_W-1:0] evHi,
  input logic [REG_W-1:0] enLo,
  input logic [REG_W-1:0] enHi,
  input logic [REG_W-1:0] stLo,
  input logic [REG_W-1:0] stHi,
  input logic             clrLo,
  input logic             clrHi,
  input logic             enHiWr
);

  localparam int LO_EPS     = REG_W / 2;
  localparam int HI_EP_BITS = (NUM_EP > LO_EPS) ? 2 * (NUM_EP - LO_EPS) : 0;
  localparam logic [REG_W-1:0] HI_IMPL = hi_impl_mask(HI_EP_BITS, NUM_DEV);

  // R4
  set_on_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((evLo | evHi) != '0) |=> (((stLo & $past(evLo)) == $past(evLo)) &&
                               ((stHi & $past(evHi)) == $past(evHi))));

  // R4
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clrLo && evLo == '0) |=> $stable(stLo));

  // R5
  w1c_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrLo && ((regWrData & ~evLo) != '0)) |=> ((stLo & $past(regWrData & ~evLo)) == '0));

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrHi && ((regWrData & evHi) != '0)) |=>
      ((stHi & $past(regWrData & evHi)) == $past(regWrData & evHi)));

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (((stLo & enLo) | (stHi & enHi)) != '0) |=> irq);

  // R8
  mask_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enLo == '0 && enHi == '0) |=> !irq);

  // R9
  hi_enable_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    enHiWr |=> (enHi == ($past(regWrData) & HI_IMPL)));

  // R10
  read_en_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_EN_LO) |=> (regRdData == $past(enLo)));

endmodule

bind usb_evt_irq usb_evt_irq_chk #(.NUM_EP(NUM_EP), .NUM_DEV(NUM_DEV)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regRdEn   (regRdEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .irq       (irq),
  .evLo      (evLo),
  .evHi      (evHi),
  .enLo      (enLo),
  .enHi      (enHi),
  .stLo      (stLo),
  .stHi      (stHi),
  .clrLo     (strb.stLoClr),
  .clrHi     (strb.stHiClr),
  .enHiWr    (strb.enHiWr)
);

// File: tb/test_usb_evt_irq.sv
`timescale 1ns/1ps
module test_usb_evt_irq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [23:0] epFifoErr = '0;
  logic [23:0] epPktDone = '0;
  logic [3:0]  devEvent = '0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  usb_evt_irq i_usb_evt_irq (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .epFifoErr(epFifoErr), .epPktDone(epPktDone), .devEvent(devEvent), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] mSt [2];
  logic [31:0] mEn [2];
  logic [31:0] mRd;
  bit          mIrq;
  bit          mRdValid;

  function automatic logic [31:0] implOf(input int w);
    return (w == 0) ? 32'hFFFF_FFFF : 32'hF000_FFFF;
  endfunction

  function automatic logic [31:0] eventsOf(input int w, input logic [23:0] err,
                                           input logic [23:0] pkt, input logic [3:0] dev);
    logic [31:0] v = '0;
    for (int b = 0; b < 32; b++) begin
      int ep;
      if (w == 0) begin
        ep = b / 2;
        v[b] = (b % 2) ? pkt[ep] : err[ep];
      end else if (b < 16) begin
        ep = 16 + b / 2;
        v[b] = (b % 2) ? pkt[ep] : err[ep];
      end else if (b >= 28) begin
        v[b] = dev[b - 28];
      end
    end
    return v;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < 2; w++) begin mSt[w] = '0; mEn[w] = '0; end
      mRd = '0; mIrq = 0; mRdValid = 0;
    end else begin
      mRdValid = regRdEn;
      if (regRdEn) mRd = (regAddr < 2) ? mEn[regAddr] : mSt[regAddr - 2];
      mIrq = ((mSt[0] & mEn[0]) != 0) || ((mSt[1] & mEn[1]) != 0);
      for (int w = 0; w < 2; w++) begin
        logic [31:0] clr;
        clr = (regWrEn && regAddr == 2'(2 + w)) ? regWrData : 32'h0;
        mSt[w] = (mSt[w] & ~clr) | eventsOf(w, epFifoErr, epPktDone, devEvent);
        if (regWrEn && regAddr == 2'(w)) mEn[w] = regWrData & implOf(w);
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      checks++;
      if (irq !== mIrq) begin
        failures++;
        $display("FAIL R7 irq per-cycle actual=%0b expected=%0b at %0t", irq, mIrq, $time);
      end
      if (mRdValid) begin
        checks++;
        if (regRdData !== mRd) begin
          failures++;
          $display("FAIL R10 read per-cycle actual=%08h expected=%08h at %0t", regRdData, mRd, $time);
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input logic [23:0] err, input logic [23:0] pkt, input logic [3:0] dev,
                     input logic wr, input logic rd, input logic [1:0] a, input logic [31:0] wd);
    @(negedge clk);
    epFifoErr = err; epPktDone = pkt; devEvent = dev;
    regWrEn = wr; regRdEn = rd; regAddr = a; regWrData = wd;
  endtask

  task automatic idle();
    cyc('0, '0, '0, 0, 0, 2'd0, '0);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic rdReg(input logic [1:0] a, input logic [31:0] exp, input string tag);
    cyc('0, '0, '0, 0, 1, a, '0);
    idle();
    chk(tag, regRdData, exp);
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [31:0] wd);
    cyc('0, '0, '0, 1, 0, a, wd);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11 reset state
    chk("R11 irq after reset", {31'b0, irq}, 32'h0);
    rdReg(2'd0, 32'h0, "R11 enable low");
    rdReg(2'd1, 32'h0, "R11 enable high");
    rdReg(2'd2, 32'h0, "R11 status low");
    rdReg(2'd3, 32'h0, "R11 status high");

    // R1 low-word packing: ep3 FIFO error -> bit 6, ep5 packet -> bit 11
    cyc(24'h000008, 24'h000020, '0, 0, 0, 2'd0, '0);
    idle();
    rdReg(2'd2, 32'h0000_0840, "R1 status low packing");
    // R4 status set although disabled, irq stays low
    chk("R4 irq low with enables clear", {31'b0, irq}, 32'h0);

    // R2 high-word packing: ep16 packet -> bit 1, ep23 error -> bit 14
    cyc(24'h800000, 24'h010000, '0, 0, 0, 2'd0, '0);
    idle();
    rdReg(2'd3, 32'h0000_4002, "R2 status high packing");

    // R3 device events: suspend -> 28, bus reset -> 31
    cyc('0, '0, 4'b1001, 0, 0, 2'd0, '0);
    idle();
    rdReg(2'd3, 32'h9000_4002, "R3 device event bits");

    // R5 write-one clears, write-zero keeps
    wrReg(2'd2, 32'h0000_0040);
    rdReg(2'd2, 32'h0000_0800, "R5 clear bit 6");
    wrReg(2'd2, 32'h0000_0000);
    rdReg(2'd2, 32'h0000_0800, "R5 zero write keeps");

    // R10 read in the same cycle as a pulse returns the old value
    cyc('0, 24'h000001, '0, 0, 1, 2'd2, '0);
    idle();
    chk("R10 read before update", regRdData, 32'h0000_0800);
    rdReg(2'd2, 32'h0000_0802, "R10 read after update");

    // R7 irq lags the enable by one registered stage; R9 mask on readback
    cyc('0, '0, '0, 1, 0, 2'd1, 32'hFFFF_FFFF);
    idle();
    chk("R7 irq not yet high", {31'b0, irq}, 32'h0);
    idle();
    chk("R7 irq high", {31'b0, irq}, 32'h1);
    rdReg(2'd1, 32'hF000_FFFF, "R9 high enable implemented bits");

    // R6 clear-all of high status while ep20 reports an error -> bit 8 stays
    cyc(24'h100000, '0, '0, 1, 0, 2'd3, 32'hFFFF_FFFF);
    idle();
    rdReg(2'd3, 32'h0000_0100, "R6 set wins over clear");

    // R8 zero enables mask everything
    wrReg(2'd1, 32'h0);
    idle();
    chk("R8 irq masked", {31'b0, irq}, 32'h0);

    // mixed random traffic, judged by the per-clock model comparison
    for (int i = 0; i < 600; i++) begin
      logic [23:0] e, p;
      logic [3:0] d;
      logic w, r;
      e = 24'($urandom & $urandom & $urandom);
      p = 24'($urandom & $urandom & $urandom);
      d = 4'($urandom & $urandom);
      w = ($urandom % 4) == 0;
      r = ($urandom % 2) == 0;
      cyc(e, p, d, w, r, 2'($urandom), $urandom);
    end
    idle();
    idle();

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL R11 watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule